// File: doc/BRIEF.md
# Safety-Gated Control Command Executor

This block carries out simple control commands that an upstream header interpreter has already decoded. Each request arrives as a one-cycle strobe carrying a four-bit operation code and a channel index. The block can hold or release a processor reset line, set or clear individual external signal lines, and reset one link channel or every link channel with a fixed-length pulse. The processor reset line and the four external lines together make up a five-pin command interface toward off-block circuitry.

Some operations are treated as safety-critical: holding the processor in reset and resetting links. These run only while a one-shot arm register is set. A dedicated arm request sets the register. Running one critical operation clears it again, so every critical operation needs a fresh arm request. A critical request that arrives while the block is not armed does nothing except raise a one-cycle refusal strobe. All outputs are registered and change on the clock edge that samples the request.

Top module: `safe_cmd_exec`

## Requirements
- R1: After reset, cpu_rst, ext_sig, link_rst, refuse and armed are all low.
- R2: A valid request with code 1 (arm) sets armed from the next cycle. An arm request while already armed keeps it set, and arm is never refused.
- R3: Code 2 (hold processor reset) is critical. When armed, it sets cpu_rst from the next cycle and clears armed on the same edge.
- R4: Code 3 (release processor reset) is not critical. It clears cpu_rst from the next cycle, whether or not the block is armed, and leaves armed unchanged.
- R5: Code 4 sets and code 5 clears the single line ext_sig[req_chan]. These codes are not critical, leave the other lines and armed unchanged, and work whether or not the block is armed.
- R6: Code 6 (reset one link) is critical. When armed and req_chan is below 3, link_rst[req_chan] goes high for exactly 4 cycles starting the next cycle, and armed clears. With req_chan equal to 3, the request has no effect at all: no pulse, no refusal, and armed stays as it was.
- R7: Code 7 (reset all links) is critical. When armed, all three link_rst bits go high together for exactly 4 cycles starting the next cycle, and armed clears.
- R8: A critical request (codes 2, 6 with a valid channel, and 7) while armed is low is not executed. In that case refuse is high for exactly the next cycle, and cpu_rst, link_rst and armed keep their course.
- R9: Only one critical operation runs per arm request. A second critical request with no arm request in between is refused.
- R10: Codes 0 and 8 to 15 have no effect. A request with req_valid low has no effect, whatever its code.
- R11: A reset of a link whose pulse is still running restarts that link's 4-cycle count from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle command request strobe |
| req_code | input | 4 | Operation code |
| req_chan | input | 2 | Channel index: a link for code 6, an external line for codes 4 and 5 |
| cpu_rst | output | 1 | Processor reset level |
| ext_sig | output | 4 | External signal levels |
| link_rst | output | 3 | Per-link reset pulses |
| refuse | output | 1 | One-cycle strobe for a refused critical request |
| armed | output | 1 | Arm register state |

## Verification
On every cycle the assertions check that armed rises only after an arm request and falls only after a critical request. They also check that a rising cpu_rst or link_rst bit always coincides with armed being consumed, that a refusal strobe happens only while disarmed and leaves cpu_rst and armed untouched, and that cpu_rst and ext_sig move only on their own codes. The exact 4-cycle pulse length, the restart of a running pulse, the ignored out-of-range link index and the refusal of a second critical request after one arm can only be shown by the bench's scenarios, where a behavioural model is compared with every output on every clock.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_ARM      = 4'd1,
    OP_CPU_HOLD = 4'd2,
    OP_CPU_FREE = 4'd3,
    OP_EXT_SET  = 4'd4,
    OP_EXT_CLR  = 4'd5,
    OP_LINK_ONE = 4'd6,
    OP_LINK_ALL = 4'd7
  } op_e;

  // operations that consume the arm register
  function automatic logic op_critical(input logic [3:0] code);
    return (code == OP_CPU_HOLD) || (code == OP_LINK_ONE) || (code == OP_LINK_ALL);
  endfunction
endpackage

// File: rtl/sce_arm_gate.sv
module sce_arm_gate
  import sce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_code,
  input  logic       chan_ok,
  output logic       go,
  output logic       armed,
  output logic       refuse
);
  logic armed_q, armed_d;
  logic refuse_q, refuse_d;
  logic relevant;

  // a link-one request with a bad index is dropped before gating
  assign relevant = req_valid && op_critical(req_code) &&
                    ((req_code != OP_LINK_ONE) || chan_ok);

  always_comb begin
    go       = relevant && armed_q;
    refuse_d = relevant && !armed_q;
    armed_d  = armed_q;
    if (go) begin
      armed_d = 1'b0;
    end else if (req_valid && (req_code == OP_ARM)) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      refuse_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      refuse_q <= refuse_d;
    end
  end

  assign armed  = armed_q;
  assign refuse = refuse_q;
endmodule

// File: rtl/sce_level_bank.sv
module sce_level_bank
  import sce_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int CHAN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_code,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              go,
  output logic              cpu_rst,
  output logic [NUM_EXT-1:0] ext_sig
);
  logic               cpu_q, cpu_d, cpu_en;
  logic [NUM_EXT-1:0] ext_q, ext_d, ext_en;

  always_comb begin
    cpu_en = 1'b0;
    cpu_d  = cpu_q;
    if (go && (req_code == OP_CPU_HOLD)) begin
      cpu_en = 1'b1;
      cpu_d  = 1'b1;
    end else if (req_valid && (req_code == OP_CPU_FREE)) begin
      cpu_en = 1'b1;
      cpu_d  = 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
      logic hit;
      assign hit       = req_valid && (req_chan == CHAN_W'(i));
      assign ext_en[i] = hit && ((req_code == OP_EXT_SET) || (req_code == OP_EXT_CLR));
      assign ext_d[i]  = (req_code == OP_EXT_SET);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ext_q[i] <= 1'b0;
        end else if (ext_en[i]) begin
          ext_q[i] <= ext_d[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= 1'b0;
    end else if (cpu_en) begin
      cpu_q <= cpu_d;
    end
  end

  assign cpu_rst = cpu_q;
  assign ext_sig = ext_q;
endmodule

// File: rtl/sce_link_pulser.sv
module sce_link_pulser
  import sce_pkg::*;
#(
  parameter int NUM_LINK  = 3,
  parameter int CHAN_W    = 2,
  parameter int PULSE_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [3:0]          req_code,
  input  logic [CHAN_W-1:0]   req_chan,
  output logic [NUM_LINK-1:0] link_rst
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  generate
    for (genvar i = 0; i < NUM_LINK; i++) begin : g_link
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             start;

      assign start = go && ((req_code == OP_LINK_ALL) ||
                            ((req_code == OP_LINK_ONE) && (req_chan == CHAN_W'(i))));

      always_comb begin
        cnt_d = cnt_q;
        if (start) begin
          cnt_d = CNT_W'(PULSE_LEN);
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign link_rst[i] = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/safe_cmd_exec.sv
module safe_cmd_exec
  import sce_pkg::*;
#(
  parameter int NUM_LINK  = 3,
  parameter int NUM_EXT   = 4,
  parameter int CHAN_W    = 2,
  parameter int PULSE_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [3:0]          req_code,
  input  logic [CHAN_W-1:0]   req_chan,
  output logic                cpu_rst,
  output logic [NUM_EXT-1:0]  ext_sig,
  output logic [NUM_LINK-1:0] link_rst,
  output logic                refuse,
  output logic                armed
);
  localparam logic [CHAN_W:0] LINK_LIM = (CHAN_W + 1)'(NUM_LINK);

  logic rst_meta, rst_sync;
  logic go, chan_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign chan_ok = ({1'b0, req_chan} < LINK_LIM);

  sce_arm_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync),
    .req_valid (req_valid),
    .req_code  (req_code),
    .chan_ok   (chan_ok),
    .go        (go),
    .armed     (armed),
    .refuse    (refuse)
  );

  sce_level_bank #(.NUM_EXT(NUM_EXT), .CHAN_W(CHAN_W)) u_levels (
    .clk       (clk),
    .rst_n     (rst_sync),
    .req_valid (req_valid),
    .req_code  (req_code),
    .req_chan  (req_chan),
    .go        (go),
    .cpu_rst   (cpu_rst),
    .ext_sig   (ext_sig)
  );

  sce_link_pulser #(.NUM_LINK(NUM_LINK), .CHAN_W(CHAN_W), .PULSE_LEN(PULSE_LEN)) u_links (
    .clk      (clk),
    .rst_n    (rst_sync),
    .go       (go),
    .req_code (req_code),
    .req_chan (req_chan),
    .link_rst (link_rst)
  );
endmodule

// File: rtl/sce_checker.sv
module sce_checker
  import sce_pkg::*;
#(
  parameter int NUM_LINK = 3,
  parameter int NUM_EXT  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [3:0]          req_code,
  input logic                cpu_rst,
  input logic [NUM_EXT-1:0]  ext_sig,
  input logic [NUM_LINK-1:0] link_rst,
  input logic                refuse,
  input logic                armed
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!cpu_rst && ext_sig == '0 && link_rst == '0 && !refuse && !armed); // R1
    end
  end

  AST_ARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(req_valid && (req_code == OP_ARM))); // R2

  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(req_valid && op_critical(req_code))); // R9

  AST_CPU_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $fell(armed)); // R3

  AST_CPU_FREE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> $past(req_valid && (req_code == OP_CPU_FREE))); // R4

  AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_sig) |-> $past(req_valid && ((req_code == OP_EXT_SET) || (req_code == OP_EXT_CLR)))); // R5

  AST_REFUSE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |-> !$past(armed)); // R8

  AST_REFUSE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |-> ($stable(cpu_rst) && !armed)); // R8

  generate
    for (genvar i = 0; i < NUM_LINK; i++) begin : g_chk
      AST_LINK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_rst[i]) |-> $fell(armed)); // R6
    end
  endgenerate
endmodule

bind safe_cmd_exec sce_checker #(.NUM_LINK(NUM_LINK), .NUM_EXT(NUM_EXT)) u_sce_checker (
  .clk       (clk),
  .rst_n     (rst_sync),
  .req_valid (req_valid),
  .req_code  (req_code),
  .cpu_rst   (cpu_rst),
  .ext_sig   (ext_sig),
  .link_rst  (link_rst),
  .refuse    (refuse),
  .armed     (armed)
);

// File: tb/safe_cmd_exec_bench.sv
module safe_cmd_exec_bench;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_code;
  logic [1:0] req_chan;
  logic       cpu_rst;
  logic [3:0] ext_sig;
  logic [2:0] link_rst;
  logic       refuse;
  logic       armed;

  int    total;
  int    bad;
  int    cyc;
  bit    done;
  string cur_req;

  // behavioural reference state
  bit m_cpu, m_arm, m_ref;
  bit m_ext [4];
  int m_cnt [3];

  safe_cmd_exec u_safe_cmd_exec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_chan(req_chan), .cpu_rst(cpu_rst), .ext_sig(ext_sig),
    .link_rst(link_rst), .refuse(refuse), .armed(armed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cpu = 0; m_arm = 0; m_ref = 0;
      for (int i = 0; i < 4; i++) m_ext[i] = 0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else begin
      bit start [3];
      for (int i = 0; i < 3; i++) start[i] = 0;
      m_ref = 0;
      if (req_valid) begin
        case (req_code)
          4'd1: m_arm = 1;
          4'd2: if (m_arm) begin m_cpu = 1; m_arm = 0; end else m_ref = 1;
          4'd3: m_cpu = 0;
          4'd4: m_ext[req_chan] = 1;
          4'd5: m_ext[req_chan] = 0;
          4'd6: if (req_chan < 3) begin
                  if (m_arm) begin start[req_chan] = 1; m_arm = 0; end else m_ref = 1;
                end
          4'd7: if (m_arm) begin
                  for (int i = 0; i < 3; i++) start[i] = 1;
                  m_arm = 0;
                end else m_ref = 1;
          default: ;
        endcase
      end
      for (int i = 0; i < 3; i++) begin
        if (start[i]) m_cnt[i] = 4;
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("cpu_rst", int'(cpu_rst), int'(m_cpu));
      check("armed", int'(armed), int'(m_arm));
      check("refuse", int'(refuse), int'(m_ref));
      for (int i = 0; i < 4; i++) check("ext_sig", int'(ext_sig[i]), int'(m_ext[i]));
      for (int i = 0; i < 3; i++) check("link_rst", int'(link_rst[i]), int'(m_cnt[i] > 0));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic send(logic [3:0] code, logic [1:0] chan);
    @(negedge clk);
    req_valid = 1'b1;
    req_code  = code;
    req_chan  = chan;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; done = 0;
    cur_req   = "R1";
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_code  = 4'd0;
    req_chan  = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: explicit reset state
    check("R1 reset cpu_rst", int'(cpu_rst), 0);
    check("R1 reset ext_sig", int'(ext_sig), 0);
    check("R1 reset link_rst", int'(link_rst), 0);
    check("R1 reset armed/refuse", int'({armed, refuse}), 0);

    cur_req = "R10";
    send(4'd0, 2'd0); send(4'd9, 2'd1); send(4'd15, 2'd2);
    idle(1);
    @(negedge clk); req_valid = 1'b0; req_code = 4'd1;
    @(negedge clk); req_code = 4'd4;
    idle(2);

    cur_req = "R8";
    send(4'd2, 2'd0); idle(1);
    send(4'd7, 2'd0); send(4'd6, 2'd1); idle(6);

    cur_req = "R2";
    send(4'd1, 2'd0); send(4'd1, 2'd3); idle(2);

    cur_req = "R3";
    send(4'd2, 2'd0); idle(2);

    cur_req = "R9";
    send(4'd6, 2'd0); send(4'd2, 2'd0); idle(6);

    cur_req = "R4";
    send(4'd3, 2'd0); idle(1);
    send(4'd1, 2'd0); send(4'd3, 2'd0); idle(2);

    cur_req = "R5";
    send(4'd4, 2'd0); send(4'd4, 2'd2); send(4'd4, 2'd3);
    send(4'd5, 2'd2); send(4'd5, 2'd1); idle(2);

    cur_req = "R6";
    send(4'd6, 2'd1); idle(7);
    send(4'd6, 2'd3); idle(2);
    send(4'd1, 2'd0); send(4'd6, 2'd3); idle(1);
    send(4'd6, 2'd2); idle(7);

    cur_req = "R7";
    send(4'd1, 2'd0); send(4'd7, 2'd0); idle(7);

    cur_req = "R11";
    send(4'd1, 2'd0); send(4'd6, 2'd0); idle(2);
    send(4'd1, 2'd0); send(4'd6, 2'd0); idle(8);

    finish_run();
  end
endmodule